// File: doc/BRIEF.md
# Handshaked Floating-Point Divider

This block divides one single-precision floating-point value by another over many clock cycles. A requester places the dividend and divisor on the operand pins and raises `req_i`. The unit captures both operands on that edge. It forms the result sign and the re-biased exponent difference. It then runs a bit-serial non-restoring division of the two significands, producing one quotient bit per cycle. After that it normalizes and packs the quotient and raises `done_o`.

The interface is a four-phase request/done exchange rather than a streaming one. The requester is the back-pressure: `done_o` and the result stay put for as long as `req_i` is held. The unit accepts no new work until `req_i` has dropped and `done_o` has fallen. Operand pins are only looked at on the capture edge.

Operands whose exponent field is zero are treated as zero. Rounding is by truncation. A zero divisor, a zero dividend, and exponent overflow or underflow are handled without running the division loop, or at packing time.

Top module: `fdiv_hs_top`

## Requirements
- R1: After reset `done_o`, `dz_o` and `ovf_o` are low and `quot_o` is all zeros.
- R2: With the unit idle, a high `req_i` at a rising edge captures both operands on that edge. `done_o` then rises and stays high, with `quot_o`, `dz_o` and `ovf_o` unchanged, for as long as `req_i` stays high.
- R3: One edge after `req_i` is seen low while `done_o` is high, `done_o` falls and the unit is idle. Changes to the operand pins after the capture edge do not affect the result.
- R4: Bit 31 of the result (the sign) is the XOR of bit 31 of the two operands, also for zero and infinity results.
- R5: The significands, each with the hidden one placed above the 23-bit fraction in bits 22:0, are divided into a 25-bit quotient, floor(A*2^24/B). If its top bit is set, bits 23:1 become the fraction and the exponent is Ed-Ev+127. Otherwise bits 22:0 become the fraction and the exponent is Ed-Ev+126. The exponents Ed and Ev are fields 30:23 of the dividend and divisor.
- R6: A divisor with exponent field zero sets `dz_o`, leaves `ovf_o` low and returns a signed infinity (exponent field all ones, fraction zero). This also holds when the dividend is zero.
- R7: A zero dividend (exponent field zero) with a nonzero divisor returns a signed zero with both flags low.
- R8: A computed exponent of 255 or more sets `ovf_o` and returns a signed infinity.
- R9: A computed exponent of 0 or less returns a signed zero with both flags low.
- R10: For a regular divide, `done_o` is high after the 27th rising edge counted from the capture edge (capture edge included). When a zero operand is detected, `done_o` is high after the 2nd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request; high starts an operation, low releases the result |
| dividend_i | input | 32 | Dividend, single-precision format |
| divisor_i | input | 32 | Divisor, single-precision format |
| done_o | output | 1 | Result valid; held while `req_i` stays high |
| quot_o | output | 32 | Packed quotient |
| dz_o | output | 1 | Divide-by-zero flag for the last result |
| ovf_o | output | 1 | Exponent overflow flag for the last result |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. This gives a 25-step division loop and exponent limits of 255 and 0. Extreme operand exponents, such as 254 over 1, reach both limits directly. With these widths a reference quotient can be formed in the bench by plain 48-bit integer division. That reference is compared with the serial loop on fixed cases and on a pseudo-random sweep of both signs and mid-range exponents. The 27-cycle and 2-cycle latencies are measured for each mode.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_FIN  = 2'd2,
    ST_DONE = 2'd3
  } fdiv_state_e;
endpackage

// File: rtl/fdiv_unpack.sv
module fdiv_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [MAN_W:0]    sig_o,
  output logic              zero_o
);
  // An all-zero exponent field is taken as zero; denormals are not kept.
  always_comb begin
    sign_o = word_i[WORD_W-1];
    exp_o  = word_i[WORD_W-2 -: EXP_W];
    zero_o = (exp_o == '0);
    sig_o  = {~zero_o, word_i[MAN_W-1:0]};
  end
endmodule

// File: rtl/fdiv_nr_core.sv
module fdiv_nr_core #(
  parameter int SIG_W = 24,
  parameter int QW    = 25,
  localparam int RW   = SIG_W + 3,
  localparam int CW   = $clog2(QW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SIG_W-1:0] num_i,
  input  logic [SIG_W-1:0] den_i,
  output logic             last_o,
  output logic [QW-1:0]    quo_o
);
  logic signed [RW-1:0] rem_q, rem_nx, den_ext, rem_dbl;
  logic [SIG_W-1:0]     den_q;
  logic [CW-1:0]        cnt_q;
  logic                 run_q;

  assign den_ext = $signed({3'b000, den_q});
  assign rem_dbl = rem_q <<< 1;
  assign last_o  = run_q && (cnt_q == CW'(QW - 1));

  // One step: the first subtracts, later steps double the partial remainder
  // and add or subtract the divisor by its sign. The quotient bit is set
  // when the new remainder is non-negative.
  always_comb begin
    if (cnt_q == '0)
      rem_nx = rem_q - den_ext;
    else if (rem_q[RW-1])
      rem_nx = rem_dbl + den_ext;
    else
      rem_nx = rem_dbl - den_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      quo_o <= '0;
    end else if (load_i) begin
      rem_q <= $signed({3'b000, num_i});
      den_q <= den_i;
      cnt_q <= '0;
      run_q <= 1'b1;
      quo_o <= '0;
    end else if (run_q) begin
      rem_q <= rem_nx;
      quo_o <= {quo_o[QW-2:0], ~rem_nx[RW-1]};
      cnt_q <= cnt_q + 1'b1;
      if (last_o) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fdiv_pack.sv
module fdiv_pack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W,
  localparam int QW     = MAN_W + 2,
  localparam int EW2    = EXP_W + 2,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1,
  localparam int EMAX   = (1 << EXP_W) - 1
) (
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_a_i,
  input  logic [EXP_W-1:0]  exp_b_i,
  input  logic [QW-1:0]     quo_i,
  input  logic              dz_i,
  input  logic              zero_num_i,
  output logic [WORD_W-1:0] word_o,
  output logic              ovf_o
);
  logic                 norm;
  logic [MAN_W-1:0]     frac;
  logic signed [EW2-1:0] exp_s;

  assign norm = quo_i[QW-1];
  assign frac = norm ? quo_i[QW-2:1] : quo_i[QW-3:0];
  assign exp_s = $signed({2'b00, exp_a_i}) - $signed({2'b00, exp_b_i})
               + $signed(EW2'(BIAS)) - $signed({{(EW2-1){1'b0}}, ~norm});

  always_comb begin
    ovf_o = 1'b0;
    if (dz_i) begin
      word_o = {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end else if (zero_num_i) begin
      word_o = {sign_i, {(WORD_W-1){1'b0}}};
    end else if (exp_s >= $signed(EW2'(EMAX))) begin
      word_o = {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      ovf_o  = 1'b1;
    end else if (exp_s <= $signed({EW2{1'b0}})) begin
      word_o = {sign_i, {(WORD_W-1){1'b0}}};
    end else begin
      word_o = {sign_i, exp_s[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/fdiv_hs_top.sv
module fdiv_hs_top #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W,
  localparam int SIG_W  = MAN_W + 1,
  localparam int QW     = MAN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [WORD_W-1:0] dividend_i,
  input  logic [WORD_W-1:0] divisor_i,
  output logic              done_o,
  output logic [WORD_W-1:0] quot_o,
  output logic              dz_o,
  output logic              ovf_o
);
  import fdiv_pkg::*;

  fdiv_state_e state_q;

  logic [1:0]       in_sign, in_zero;
  logic [EXP_W-1:0] in_exp [2];
  logic [SIG_W-1:0] in_sig [2];

  // Two identical field decoders, one per operand.
  for (genvar g = 0; g < 2; g++) begin : g_unpack
    fdiv_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) unpack_i (
      .word_i (g == 0 ? dividend_i : divisor_i),
      .sign_o (in_sign[g]),
      .exp_o  (in_exp[g]),
      .sig_o  (in_sig[g]),
      .zero_o (in_zero[g])
    );
  end

  logic             sign_q, dz_q, zn_q;
  logic [EXP_W-1:0] ea_q, eb_q;
  logic             take, special, core_load, core_last;
  logic [QW-1:0]    core_quo;
  logic [WORD_W-1:0] pk_word;
  logic             pk_ovf;

  assign take      = (state_q == ST_IDLE) && req_i;
  assign special   = in_zero[0] | in_zero[1];
  assign core_load = take && !special;

  fdiv_nr_core #(.SIG_W(SIG_W), .QW(QW)) core_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (core_load),
    .num_i  (in_sig[0]),
    .den_i  (in_sig[1]),
    .last_o (core_last),
    .quo_o  (core_quo)
  );

  fdiv_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) pack_i (
    .sign_i     (sign_q),
    .exp_a_i    (ea_q),
    .exp_b_i    (eb_q),
    .quo_i      (core_quo),
    .dz_i       (dz_q),
    .zero_num_i (zn_q),
    .word_o     (pk_word),
    .ovf_o      (pk_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sign_q  <= 1'b0;
      dz_q    <= 1'b0;
      zn_q    <= 1'b0;
      ea_q    <= '0;
      eb_q    <= '0;
      quot_o  <= '0;
      dz_o    <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          sign_q  <= in_sign[0] ^ in_sign[1];
          ea_q    <= in_exp[0];
          eb_q    <= in_exp[1];
          dz_q    <= in_zero[1];
          zn_q    <= in_zero[0];
          state_q <= special ? ST_FIN : ST_DIV;
        end
        ST_DIV:  if (core_last) state_q <= ST_FIN;
        ST_FIN: begin
          quot_o  <= pk_word;
          dz_o    <= dz_q;
          ovf_o   <= pk_ovf;
          state_q <= ST_DONE;
        end
        ST_DONE: if (!req_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/fdiv_hs_chk.sv
module fdiv_hs_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              done_o,
  input logic [WORD_W-1:0] quot_o,
  input logic              dz_o,
  input logic              ovf_o
);
  assert_done_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && req_i |=> done_o);

  assert_result_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && req_i |=> $stable(quot_o) && $stable(dz_o) && $stable(ovf_o));

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !req_i |=> !done_o);

  assert_dz_infinity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && dz_o |-> !ovf_o && (quot_o[WORD_W-2 -: EXP_W] == '1)
                       && (quot_o[MAN_W-1:0] == '0));

  assert_ovf_infinity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && ovf_o |-> (quot_o[WORD_W-2 -: EXP_W] == '1)
                        && (quot_o[MAN_W-1:0] == '0));
endmodule

bind fdiv_hs_top fdiv_hs_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .req_i  (req_i),
  .done_o (done_o),
  .quot_o (quot_o),
  .dz_o   (dz_o),
  .ovf_o  (ovf_o)
);

// File: tb/fdiv_hs_top_tb_top.sv
`timescale 1ns/1ps
module fdiv_hs_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [31:0] divisor_i = '0;
  logic        done_o, dz_o, ovf_o;
  logic [31:0] quot_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  fdiv_hs_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .done_o(done_o), .quot_o(quot_o), .dz_o(dz_o), .ovf_o(ovf_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference from the requirements: {dz, ovf, word}.
  function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b);
    logic s;
    logic [47:0] q;
    int e;
    logic [22:0] f;
    s = a[31] ^ b[31];
    if (b[30:23] == 0) return {2'b10, s, 8'hFF, 23'd0};
    if (a[30:23] == 0) return {2'b00, s, 31'd0};
    q = {1'b1, a[22:0], 24'd0} / {24'd0, 1'b1, b[22:0]};
    if (q[24]) begin
      f = q[23:1]; e = int'(a[30:23]) - int'(b[30:23]) + 127;
    end else begin
      f = q[22:0]; e = int'(a[30:23]) - int'(b[30:23]) + 126;
    end
    if (e >= 255) return {2'b01, s, 8'hFF, 23'd0};
    if (e <= 0) return {2'b00, s, 31'd0};
    return {2'b00, s, e[7:0], f};
  endfunction

  // Runs one divide; optionally scrambles operands after capture.
  task automatic run_div(input logic [31:0] a, input logic [31:0] b, input bit scramble,
                         output logic [33:0] res, output int lat);
    @(negedge clk);
    dividend_i = a; divisor_i = b; req_i = 1'b1;
    lat = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      lat++;
      if (scramble && lat == 3) begin dividend_i = ~a; divisor_i = a; end
      if (done_o) break;
    end
    res = {dz_o, ovf_o, quot_o};
  endtask

  task automatic release_req();
    req_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic div_check(input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [33:0] r, e;
    int lat;
    run_div(a, b, 1'b0, r, lat);
    e = model(a, b);
    check(r == e, tag, 64'(r), 64'(e));
    release_req();
  endtask

  task automatic t_reset();
    check(!done_o && !dz_o && !ovf_o && quot_o == 0, "R1 reset state",
          64'({done_o, dz_o, ovf_o, quot_o}), 64'(0));
  endtask

  task automatic t_basic();
    logic [33:0] r;
    int lat;
    run_div(32'h40C00000, 32'h40000000, 1'b0, r, lat);
    check(r == {2'b00, 32'h40400000}, "R5 6/2", 64'(r), 64'h40400000);
    check(lat == 27, "R10 regular latency", 64'(lat), 64'd27);
    release_req();
    run_div(32'h3F800000, 32'h40400000, 1'b0, r, lat);
    check(r == {2'b00, 32'h3EAAAAAA}, "R5 1/3 truncated, shift left", 64'(r), 64'h3EAAAAAA);
    release_req();
  endtask

  task automatic t_signs();
    div_check(32'hC0C00000, 32'h40000000, "R4 neg/pos");
    div_check(32'h40C00000, 32'hC0000000, "R4 pos/neg");
    div_check(32'hC0C00000, 32'hC0000000, "R4 neg/neg");
  endtask

  task automatic t_divzero();
    logic [33:0] r;
    int lat;
    run_div(32'hC1200000, 32'h00000000, 1'b0, r, lat);
    check(r == {2'b10, 32'hFF800000}, "R6 neg/zero -inf dz", 64'(r), {30'd0, 2'b10, 32'hFF800000});
    check(lat == 2, "R10 special latency", 64'(lat), 64'd2);
    release_req();
    run_div(32'h00000000, 32'h80000000, 1'b0, r, lat);
    check(r == {2'b10, 32'hFF800000}, "R6 zero/zero", 64'(r), {30'd0, 2'b10, 32'hFF800000});
    release_req();
  endtask

  task automatic t_zero_num();
    logic [33:0] r;
    int lat;
    run_div(32'h80000000, 32'h40000000, 1'b0, r, lat);
    check(r == {2'b00, 32'h80000000}, "R7 -0/2", 64'(r), 64'h80000000);
    check(lat == 2, "R10 zero dividend latency", 64'(lat), 64'd2);
    release_req();
  endtask

  task automatic t_ranges();
    logic [33:0] r;
    int lat;
    run_div(32'h7F000000, 32'h00800000, 1'b0, r, lat);
    check(r == {2'b01, 32'h7F800000}, "R8 overflow", 64'(r), {30'd0, 2'b01, 32'h7F800000});
    release_req();
    run_div(32'h00800000, 32'hFF000000, 1'b0, r, lat);
    check(r == {2'b00, 32'h80000000}, "R9 underflow flush", 64'(r), 64'h80000000);
    release_req();
    // 1.0 * 2^0 over 1.5 * 2^-126: exponent 127+126+? computes 126+126=252, in range
    div_check(32'h3F800000, 32'h00C00000, "R5 near top exponent");
  endtask

  task automatic t_handshake();
    logic [33:0] r, hold;
    int lat;
    run_div(32'h41100000, 32'h40400000, 1'b1, r, lat);
    check(r == model(32'h41100000, 32'h40400000), "R3 operand change ignored",
          64'(r), 64'(model(32'h41100000, 32'h40400000)));
    hold = r;
    dividend_i = 32'h3F800000; divisor_i = 32'h00000000;
    repeat (6) @(negedge clk);
    check(done_o && {dz_o, ovf_o, quot_o} == hold, "R2 done and result held",
          64'({done_o, dz_o, ovf_o, quot_o}), 64'({1'b1, hold}));
    req_i = 1'b0;
    @(negedge clk);
    check(!done_o, "R3 done falls one edge after release", 64'(done_o), 64'd0);
    // Immediate new request is accepted.
    run_div(32'h40C00000, 32'h40000000, 1'b0, r, lat);
    check(r == {2'b00, 32'h40400000} && lat == 27, "R2 back-to-back request",
          64'(r), 64'h40400000);
    release_req();
  endtask

  task automatic t_sweep();
    logic [31:0] x = 32'h1234ABCD;
    logic [31:0] a, b;
    for (int i = 0; i < 40; i++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      a = {x[31], 8'd64 + {1'b0, x[6:0]}, x[30:8]};
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      b = {x[31], 8'd64 + {1'b0, x[6:0]}, x[30:8]};
      div_check(a, b, "R5 sweep");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_signs();
    t_divzero();
    t_zero_num();
    t_ranges();
    t_handshake();
    t_sweep();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end
endmodule